// File: doc/BRIEF.md
# Complement-Mirrored Protected Register Bank

This block holds a small set of critical variables in a way that exposes silent corruption. Every write lands in two physically separate banks. The primary bank receives the value as given. The mirror bank receives the same value with every bit inverted. Each read fetches both copies at the same index and checks that every bit of one is the inverse of the matching bit of the other. With voting enabled, a third bank keeps another true copy, and the block returns the bitwise two-of-three majority of the three copies.

A detected problem raises a per-read flag. It also updates status that survives later reads: a flag that stays set and records the index of the first bad entry, and a count of every detection. Only an explicit clear input resets that status. A restore input rewrites every entry of every bank to its default value in one cycle. A fault-injection input flips one chosen bit of one chosen entry in one chosen bank, so that detection and correction can be exercised.

Top module: `mirror_guard_bank`

## Requirements
- R1: A write stores the data unchanged in the primary bank and inverted in the mirror bank. A read issued with `rd_en` returns the stored data on `rd_data` with `rd_valid` high after the next clock edge. On a clean entry `rd_err` and `rd_fixed` are low.
- R2: If any single bit of an entry is flipped in the primary bank (`inj_bank` = 0) or in the mirror bank (`inj_bank` = 1), the next read of that entry raises `rd_err`.
- R3: An entry whose mirror copy equals its primary copy, instead of being its inverse, raises `rd_err` when read.
- R4: If the same bit position is flipped in both the primary and the mirror copy, `rd_err` stays low, which is a known limit of the complement check. The third copy still raises `rd_fixed`, and `rd_data` returns the bitwise majority of the three copies.
- R5: With voting enabled (`VOTE` = 1), `rd_data` is the bitwise majority of the primary copy, the inverted mirror copy and the third copy (`inj_bank` = 2). `rd_fixed` is high when any of the three copies differs from that majority and low otherwise.
- R6: The first read that raises `rd_err` or `rd_fixed` sets `err_sticky` and stores the read index in `err_idx`. Later detections leave `err_idx` unchanged until the status is cleared.
- R7: `err_count` increases by one on each read that raises `rd_err` or `rd_fixed`, and stops at its maximum value, 255 by default.
- R8: `err_clr` zeroes `err_sticky`, `err_idx` and `err_count`. It takes priority over a detection in the same cycle.
- R9: `restore` rewrites every entry to its default in one cycle: the primary and third banks get `(DFLT_BASE + index) mod 2^DATA_W` and the mirror bank gets its inverse. This removes injected faults, and `restore` takes priority over a write in the same cycle.
- R10: After reset every entry holds its default value, and `rd_valid`, `rd_data`, `rd_err`, `rd_fixed`, `err_sticky`, `err_idx` and `err_count` are zero.
- R11: A read and a write to the same index in the same cycle return the contents from before the write. If a flip and a write hit the same entry in the same cycle, the write wins.
- R12: `inj_bank` = 3 changes nothing. While `rd_en` is low, `rd_valid` is low and `rd_data`, `rd_err` and `rd_fixed` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Write entry index |
| wr_data | input | DATA_W | Write value |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Read entry index |
| restore | input | 1 | Rewrite all entries to defaults |
| inj_en | input | 1 | Fault-injection strobe |
| inj_bank | input | 2 | Target bank: 0 primary, 1 mirror, 2 third, 3 none |
| inj_idx | input | IDX_W | Target entry for injection |
| inj_bit | input | BIT_W | Bit position to flip |
| err_clr | input | 1 | Clear persistent error status |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read data (majority in voting mode) |
| rd_err | output | 1 | Primary and mirror copies are not exact complements |
| rd_fixed | output | 1 | A copy disagreed with the majority |
| err_sticky | output | 1 | A detection has happened since the last clear |
| err_idx | output | IDX_W | Index of the first detection |
| err_count | output | CNT_W | Saturating count of detections |

## Verification
The hardest states to reach are the ones where the copies disagree in a structured way. Examples are a mirror that equals its primary, and identical flips in two banks that cancel out in the complement test. The stimulus builds these states by repeated single-bit injections: all eight bits of one mirror entry for the equal-copies case, and one shared bit position in the primary and mirror banks for the escape case. Counter saturation needs more than 255 detections, so one corrupted entry is read back repeatedly. A seeded random phase then mixes writes, reads, injections, clears and restores against a reference model of the three banks.

// File: rtl/prb_pkg.sv
`timescale 1ns/1ps
package prb_pkg;
    // Bank selector used by the fault-injection port
    typedef enum logic [1:0] {
        BANK_PRI  = 2'd0,
        BANK_MIR  = 2'd1,
        BANK_TRD  = 2'd2,
        BANK_NONE = 2'd3
    } bank_sel_e;
endpackage

// File: rtl/prb_bank.sv
`timescale 1ns/1ps
module prb_bank #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 8,
    parameter bit INVERT    = 1'b0,
    parameter int DFLT_BASE = 'hA5,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flip_en,
    input  logic [IDX_W-1:0]  flip_idx,
    input  logic [BIT_W-1:0]  flip_bit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    function automatic logic [DATA_W-1:0] dflt(input int i);
        logic [DATA_W-1:0] v;
        v = DATA_W'(DFLT_BASE + i);
        return INVERT ? ~v : v;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (restore) begin
                mem_d[i] = dflt(i);
            end else begin
                if (flip_en && flip_idx == IDX_W'(i))
                    mem_d[i] = mem_q[i] ^ (DATA_W'(1) << flip_bit);
                if (wr_en && wr_idx == IDX_W'(i))
                    mem_d[i] = INVERT ? ~wr_data : wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= dflt(i);
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/prb_vote.sv
`timescale 1ns/1ps
module prb_vote #(
    parameter int DATA_W = 8,
    parameter bit VOTE   = 1'b1
) (
    input  logic [DATA_W-1:0] pri_word,
    input  logic [DATA_W-1:0] mir_word,
    input  logic [DATA_W-1:0] trd_word,
    output logic [DATA_W-1:0] data_out,
    output logic              mismatch,
    output logic              fixed
);
    logic [DATA_W-1:0] mir_true;
    logic [DATA_W-1:0] maj;

    always_comb begin
        mir_true = ~mir_word;
        mismatch = (pri_word ^ mir_word) != {DATA_W{1'b1}};
        maj      = (pri_word & mir_true) | (pri_word & trd_word) | (mir_true & trd_word);
        if (VOTE) begin
            data_out = maj;
            fixed    = (pri_word != maj) || (mir_true != maj) || (trd_word != maj);
        end else begin
            data_out = pri_word;
            fixed    = 1'b0;
        end
    end
endmodule

// File: rtl/mirror_guard_bank.sv
`timescale 1ns/1ps
module mirror_guard_bank #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 8,
    parameter int CNT_W     = 8,
    parameter bit VOTE      = 1'b1,
    parameter int DFLT_BASE = 'hA5,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              restore,
    input  logic              inj_en,
    input  logic [1:0]        inj_bank,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [BIT_W-1:0]  inj_bit,
    input  logic              err_clr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              rd_fixed,
    output logic              err_sticky,
    output logic [IDX_W-1:0]  err_idx,
    output logic [CNT_W-1:0]  err_count
);
    import prb_pkg::*;

    localparam int NBANK = VOTE ? 3 : 2;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              err;
        logic              fixed;
        logic              sticky;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] word [3];
    logic [DATA_W-1:0] chk_data;
    logic              chk_mis, chk_fix;

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            prb_bank #(
                .DATA_W(DATA_W), .DEPTH(DEPTH),
                .INVERT(b == 1), .DFLT_BASE(DFLT_BASE)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .restore(restore),
                .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
                .flip_en(inj_en && inj_bank == 2'(b)),
                .flip_idx(inj_idx), .flip_bit(inj_bit),
                .rd_idx(rd_idx), .rd_word(word[b])
            );
        end
        if (!VOTE) begin : g_no_third
            assign word[2] = '0;
        end
    endgenerate

    prb_vote #(.DATA_W(DATA_W), .VOTE(VOTE)) u_vote (
        .pri_word(word[BANK_PRI]),
        .mir_word(word[BANK_MIR]),
        .trd_word(word[BANK_TRD]),
        .data_out(chk_data),
        .mismatch(chk_mis),
        .fixed(chk_fix)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_en;
        if (rd_en) begin
            st_d.data  = chk_data;
            st_d.err   = chk_mis;
            st_d.fixed = chk_fix;
        end
        if (err_clr) begin
            st_d.sticky = 1'b0;
            st_d.idx    = '0;
            st_d.cnt    = '0;
        end else if (rd_en && (chk_mis || chk_fix)) begin
            if (!st_q.sticky) begin
                st_d.sticky = 1'b1;
                st_d.idx    = rd_idx;
            end
            if (st_q.cnt != {CNT_W{1'b1}}) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid   = st_q.vld;
    assign rd_data    = st_q.data;
    assign rd_err     = st_q.err;
    assign rd_fixed   = st_q.fixed;
    assign err_sticky = st_q.sticky;
    assign err_idx    = st_q.idx;
    assign err_count  = st_q.cnt;

    // R1
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data) && $stable(rd_err)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clr) |=> (err_sticky && $stable(err_idx)));

    // R7
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> err_count >= $past(err_count));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (!err_sticky && err_count == '0));

    // R6
    err_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (rd_err || rd_fixed) && !$past(err_clr)) |-> err_sticky);
endmodule

// File: tb/tb_mirror_guard_bank.sv
`timescale 1ns/1ps
module tb_mirror_guard_bank;
    localparam int W = 8, D = 8, IW = 3, BW = 3;
    localparam logic [7:0] BASE = 8'hA5;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, restore = 0, inj_en = 0, err_clr = 0;
    logic [IW-1:0] wr_idx = 0, rd_idx = 0, inj_idx = 0;
    logic [W-1:0]  wr_data = 0;
    logic [1:0]    inj_bank = 0;
    logic [BW-1:0] inj_bit = 0;
    logic rd_valid, rd_err, rd_fixed, err_sticky;
    logic [W-1:0]  rd_data;
    logic [IW-1:0] err_idx;
    logic [7:0]    err_count;

    mirror_guard_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .restore(restore), .inj_en(inj_en),
        .inj_bank(inj_bank), .inj_idx(inj_idx), .inj_bit(inj_bit), .err_clr(err_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .rd_fixed(rd_fixed),
        .err_sticky(err_sticky), .err_idx(err_idx), .err_count(err_count)
    );

    always #10 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done = 0;

    // reference model of the three banks (raw stored contents)
    logic [W-1:0] mp [D], mm [D], mt [D];
    logic x_vld = 0, x_err = 0, x_fix = 0, x_sticky = 0;
    logic [W-1:0] x_data = 0;
    logic [IW-1:0] x_idx = 0;
    logic [7:0] x_cnt = 0;

    function automatic logic [W-1:0] maj3(input logic [W-1:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < D; i++) begin
            mp[i] = BASE + 8'(i);
            mm[i] = ~(BASE + 8'(i));
            mt[i] = BASE + 8'(i);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [IW-1:0] wi, input logic [W-1:0] wd,
                       input logic re, input logic [IW-1:0] ri, input logic rs,
                       input logic ie, input logic [1:0] ib, input logic [IW-1:0] ii,
                       input logic [BW-1:0] ibit, input logic clr, input string tag);
        logic [W-1:0] mi, dd;
        logic e, f;
        wr_en = we; wr_idx = wi; wr_data = wd; rd_en = re; rd_idx = ri;
        restore = rs; inj_en = ie; inj_bank = ib; inj_idx = ii; inj_bit = ibit; err_clr = clr;
        mi = ~mm[ri];
        dd = maj3(mp[ri], mi, mt[ri]);
        e  = (mp[ri] ^ mm[ri]) != 8'hFF;
        f  = (mp[ri] != dd) || (mi != dd) || (mt[ri] != dd);
        x_vld = re;
        if (re) begin x_data = dd; x_err = e; x_fix = f; end
        if (clr) begin
            x_sticky = 0; x_idx = 0; x_cnt = 0;
        end else if (re && (e || f)) begin
            if (!x_sticky) begin x_sticky = 1; x_idx = ri; end
            if (x_cnt != 8'hFF) x_cnt++;
        end
        if (rs) model_defaults();
        else begin
            if (ie) begin
                case (ib)
                    2'd0: mp[ii][ibit] = ~mp[ii][ibit];
                    2'd1: mm[ii][ibit] = ~mm[ii][ibit];
                    2'd2: mt[ii][ibit] = ~mt[ii][ibit];
                    default: ;
                endcase
            end
            if (we) begin mp[wi] = wd; mm[wi] = ~wd; mt[wi] = wd; end
        end
        @(posedge clk); @(negedge clk);
        chk(rd_valid == x_vld, tag, "rd_valid", rd_valid, x_vld);
        chk(rd_data == x_data, tag, "rd_data", rd_data, x_data);
        chk(rd_err == x_err, tag, "rd_err", rd_err, x_err);
        chk(rd_fixed == x_fix, tag, "rd_fixed", rd_fixed, x_fix);
        chk(err_sticky == x_sticky, tag, "err_sticky", err_sticky, x_sticky);
        chk(err_idx == x_idx, tag, "err_idx", err_idx, x_idx);
        chk(err_count == x_cnt, tag, "err_count", err_count, x_cnt);
    endtask

    task automatic wr(input logic [IW-1:0] i, input logic [W-1:0] v, input string tag);
        cyc(1, i, v, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic rd(input logic [IW-1:0] i, input string tag);
        cyc(0, 0, 0, 1, i, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic inj(input logic [1:0] b, input logic [IW-1:0] i,
                       input logic [BW-1:0] bt, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, b, i, bt, 0, tag);
    endtask

    initial begin
        #(20 * 100000);
        nerr++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1));
        model_defaults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10: reset state at the ports
        chk(rd_valid == 0 && rd_data == 0 && rd_err == 0 && rd_fixed == 0, "R10", "read outs",
            {rd_valid, rd_err, rd_fixed, rd_data}, 0);
        chk(err_sticky == 0 && err_idx == 0 && err_count == 0, "R10", "status",
            {err_sticky, err_idx, err_count}, 0);
        for (int i = 0; i < D; i++) rd(3'(i), "R10");

        // R1: clean store and read back
        wr(3'd2, 8'h3C, "R1");
        rd(3'd2, "R1");
        // R11: read during write of same entry sees old value
        cyc(1, 3'd2, 8'h55, 1, 3'd2, 0, 0, 0, 0, 0, 0, "R11");
        rd(3'd2, "R11");
        // R11: flip and write same entry, write wins
        cyc(1, 3'd3, 8'h99, 0, 0, 0, 1, 2'd0, 3'd3, 3'd2, 0, "R11");
        rd(3'd3, "R11");
        // R12: idle cycle holds read outputs
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
        // R2 primary flip, R6 first index
        inj(2'd0, 3'd2, 3'd3, "R2");
        rd(3'd2, "R2");
        // R2 mirror flip, R6 index unchanged
        wr(3'd4, 8'hC3, "R2");
        inj(2'd1, 3'd4, 3'd7, "R2");
        rd(3'd4, "R6");
        // R5: third copy flip corrected
        inj(2'd2, 3'd5, 3'd0, "R5");
        rd(3'd5, "R5");
        // R3: mirror made equal to primary
        wr(3'd6, 8'h0F, "R3");
        for (int b = 0; b < W; b++) inj(2'd1, 3'd6, 3'(b), "R3");
        rd(3'd6, "R3");
        // R4: same bit flipped in primary and mirror
        wr(3'd7, 8'hF0, "R4");
        inj(2'd0, 3'd7, 3'd1, "R4");
        inj(2'd1, 3'd7, 3'd1, "R4");
        rd(3'd7, "R4");
        // R12: bank code 3 touches nothing
        inj(2'd3, 3'd1, 3'd5, "R12");
        rd(3'd1, "R12");
        // R8: clear wins over a simultaneous detection
        cyc(0, 0, 0, 1, 3'd7, 0, 0, 0, 0, 0, 1, "R8");
        rd(3'd7, "R6");
        // R9: restore beats a write, clears faults
        cyc(1, 3'd0, 8'h11, 0, 0, 1, 0, 0, 0, 0, 0, "R9");
        for (int i = 0; i < D; i++) rd(3'(i), "R9");
        // R7: counter saturation
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
        inj(2'd0, 3'd0, 3'd4, "R7");
        for (int k = 0; k < 260; k++) rd(3'd0, "R7");
        // seeded random mix against the model
        for (int k = 0; k < 600; k++) begin
            cyc(($urandom % 10) < 3, 3'($urandom), 8'($urandom),
                ($urandom % 10) < 6, 3'($urandom), ($urandom % 50) == 0,
                ($urandom % 10) < 2, 2'($urandom), 3'($urandom), 3'($urandom),
                ($urandom % 40) == 0, "R5");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule